// File: doc/BRIEF.md
# Flash Command Interface Decoder

This block is the command front end of an 8-bit, byte-addressed parallel NOR flash model with a 20-bit address. Bytes written on the bus are decoded as commands. The last valid command picks where later bus reads come from: the memory array, a two-byte identifier table, or the status register. A separate write/erase engine supplies a busy flag and the status byte. The decoder hands that engine a one-cycle request when an erase setup byte is followed by an erase confirm byte. It also pulses a clear request when the clear-status command is written.

All bus strobes are active low and sampled on the block clock. A command write is taken in the cycle where write enable falls while chip enable is low. The mode, the erase request and the clear pulse all change at that clock edge. A read cycle is open while chip enable and output enable are both low. The status byte shown during a read is frozen at the first clock edge of that read cycle, and it stays frozen until either strobe goes high again. The array itself is a small reset-loaded register file that stands in for real storage.

Top module: `flash_cmd_front`

## Requirements
- R1: After reset the read mode is array. Array reads return the stub byte {addr[3:0], ~addr[3:0]}. Writing FFH while the engine is idle selects array mode again.
- R2: Writing 90H selects identifier mode. A read at address 0 returns 89H, a read at address 1 returns A2H, and a read at any other address returns 00H.
- R3: Writing 70H selects status mode, in which every read returns the status byte from the engine.
- R4: A read mode persists across any number of reads. A byte other than FFH, 90H, 70H, 50H or 20H (D0H included when no erase setup is pending) leaves the mode unchanged.
- R5: While eng_busy is high, an FFH write does not change the mode. Other commands are still accepted.
- R6: 20H followed by D0H raises erase_go for exactly one cycle, with erase_addr equal to the address of the D0H write, and switches to status mode.
- R7: 20H followed by any byte other than D0H raises no erase_go. The setup is dropped and the mode becomes status.
- R8: Writing 50H raises clr_stat for exactly one cycle and keeps the current mode.
- R9: In status mode, the byte driven during a read is the engine status sampled at the first clock edge where ce_n and oe_n are both low. It holds until one of them goes high and the read restarts.
- R10: dout_en is high only while ce_n and oe_n are both low. When dout_en is low, dout is 00H.
- R11: A we_n falling edge while ce_n is high is not a command write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low; a falling edge writes a command |
| addr | input | 20 | Byte address |
| din | input | 8 | Command byte on writes |
| eng_busy | input | 1 | Write/erase engine is running |
| status_in | input | 8 | Live status byte from the engine |
| dout | output | 8 | Read data |
| dout_en | output | 1 | Read data is being driven |
| erase_go | output | 1 | One-cycle erase request to the engine |
| erase_addr | output | 20 | Block address for the erase request |
| clr_stat | output | 1 | One-cycle request to clear status error bits |

## Verification
Every byte value from 00H to FFH is written while identifier mode is active. The manufacturer byte then reveals whether any code outside the valid set disturbs the mode. The array and identifier tables are swept over all stub addresses and over several high addresses, which separates address aliasing from decoding of the full address. Erase pairs are tried both well-formed and broken, and with the engine idle and busy. This shows whether erase_go depends on the byte order and on the confirm byte, and whether only FFH is locked out while the engine is busy. Status reads in which the engine value changes in the middle of a read, and reads in which chip enable falls after output enable, show whether capture follows the later strobe edge.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [1:0] {
    MODE_ARR  = 2'd0,
    MODE_ID   = 2'd1,
    MODE_STAT = 2'd2
  } rd_mode_e;

  localparam logic [7:0] CMD_READ   = 8'hFF;
  localparam logic [7:0] CMD_IDENT  = 8'h90;
  localparam logic [7:0] CMD_STAT   = 8'h70;
  localparam logic [7:0] CMD_CLR    = 8'h50;
  localparam logic [7:0] CMD_ESETUP = 8'h20;
  localparam logic [7:0] CMD_ECONF  = 8'hD0;

  localparam logic [7:0] ID_MAKER  = 8'h89;
  localparam logic [7:0] ID_DEVICE = 8'hA2;

  // identifier table: slot 0 maker, slot 1 device, else zero
  function automatic logic [7:0] id_byte(input logic is_zero, input logic is_one);
    if (is_zero)     return ID_MAKER;
    else if (is_one) return ID_DEVICE;
    else             return 8'h00;
  endfunction

  // reset content of one stub array entry
  function automatic logic [7:0] stub_seed(input int unsigned idx);
    logic [3:0] nib;
    nib = 4'(idx);
    return {nib, ~nib};
  endfunction
endpackage

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_evt,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              eng_busy,
  output rd_mode_e          mode,
  output logic              erase_go,
  output logic [ADDR_W-1:0] erase_addr,
  output logic              clr_stat
);
  rd_mode_e          mode_q, mode_d;
  logic              setup_q, setup_d;
  logic              go_d, clr_d;
  logic [ADDR_W-1:0] ea_q, ea_d;
  logic              ff_blocked;

  assign ff_blocked = wr_evt && !setup_q && (wr_data == CMD_READ) && eng_busy;

  always_comb begin
    mode_d  = mode_q;
    setup_d = setup_q;
    go_d    = 1'b0;
    clr_d   = 1'b0;
    ea_d    = ea_q;
    if (wr_evt) begin
      if (setup_q) begin
        setup_d = 1'b0;
        mode_d  = MODE_STAT;
        if (wr_data == CMD_ECONF) begin
          go_d = 1'b1;
          ea_d = wr_addr;
        end
      end else begin
        case (wr_data)
          CMD_READ:   if (!eng_busy) mode_d = MODE_ARR;
          CMD_IDENT:  mode_d  = MODE_ID;
          CMD_STAT:   mode_d  = MODE_STAT;
          CMD_CLR:    clr_d   = 1'b1;
          CMD_ESETUP: setup_d = 1'b1;
          default:    ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= MODE_ARR;
      setup_q  <= 1'b0;
      erase_go <= 1'b0;
      clr_stat <= 1'b0;
      ea_q     <= '0;
    end else begin
      mode_q   <= mode_d;
      setup_q  <= setup_d;
      erase_go <= go_d;
      clr_stat <= clr_d;
      ea_q     <= ea_d;
    end
  end

  assign mode       = mode_q;
  assign erase_addr = ea_q;

  // R5
  busy_ff_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ff_blocked |=> (mode_q == $past(mode_q)));

  // R6
  erase_to_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |-> (mode_q == MODE_STAT));

  // R8
  clear_keeps_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stat |-> (mode_q == $past(mode_q)));

  // R6
  single_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({erase_go, clr_stat}));
endmodule

// File: rtl/flash_stat_latch.sv
module flash_stat_latch (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_now,
  input  logic [7:0] stat_in,
  output logic       rd_start,
  output logic [7:0] stat_out
);
  logic       rd_q;
  logic [7:0] lat_q;

  // a read held through reset counts as already started
  assign rd_start = rd_now && !rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q  <= 1'b1;
      lat_q <= '0;
    end else begin
      rd_q <= rd_now;
      if (rd_start) lat_q <= stat_in;
    end
  end

  // the first cycle of a read shows the value being captured
  assign stat_out = rd_start ? stat_in : lat_q;

  // R9
  frozen_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_now && !rd_start) |-> (stat_out == $past(stat_out)));
endmodule

// File: rtl/flash_read_mux.sv
module flash_read_mux
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int ARR_AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rd_mode_e          mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        stat_val,
  input  logic              rd_now,
  output logic [7:0]        dout,
  output logic              dout_en
);
  localparam int ARR_DEPTH = 1 << ARR_AW;

  logic [7:0] arr_q [ARR_DEPTH];
  logic [7:0] sel;

  for (genvar i = 0; i < ARR_DEPTH; i++) begin : g_stub
    always_ff @(posedge clk) begin
      if (!rst_n) arr_q[i] <= stub_seed(i);
    end
  end

  always_comb begin
    case (mode)
      MODE_ID:   sel = id_byte(addr == ADDR_W'(0), addr == ADDR_W'(1));
      MODE_STAT: sel = stat_val;
      default:   sel = arr_q[addr[ARR_AW-1:0]];
    endcase
  end

  assign dout_en = rd_now;
  assign dout    = rd_now ? sel : 8'h00;

  // R2
  id_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_now && mode == MODE_ID && addr > ADDR_W'(1)) |-> (dout == 8'h00));
endmodule

// File: rtl/flash_cmd_front.sv
module flash_cmd_front
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int ARR_AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  input  logic              eng_busy,
  input  logic [7:0]        status_in,
  output logic [7:0]        dout,
  output logic              dout_en,
  output logic              erase_go,
  output logic [ADDR_W-1:0] erase_addr,
  output logic              clr_stat
);
  logic       we_q;
  logic       wr_evt;
  logic       rd_now;
  logic       rd_start;
  logic [7:0] stat_frozen;
  rd_mode_e   mode;

  always_ff @(posedge clk) begin
    if (!rst_n) we_q <= 1'b1;
    else        we_q <= we_n;
  end

  assign wr_evt = !ce_n && we_q && !we_n;
  assign rd_now = !ce_n && !oe_n;

  flash_cmd_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .wr_data(din), .wr_addr(addr),
    .eng_busy(eng_busy), .mode(mode), .erase_go(erase_go),
    .erase_addr(erase_addr), .clr_stat(clr_stat)
  );

  flash_stat_latch u_stat (
    .clk(clk), .rst_n(rst_n), .rd_now(rd_now), .stat_in(status_in),
    .rd_start(rd_start), .stat_out(stat_frozen)
  );

  flash_read_mux #(.ADDR_W(ADDR_W), .ARR_AW(ARR_AW)) u_mux (
    .clk(clk), .rst_n(rst_n), .mode(mode), .addr(addr), .stat_val(stat_frozen),
    .rd_now(rd_now), .dout(dout), .dout_en(dout_en)
  );

  // R4 R11
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_evt |=> (mode == $past(mode)));

  // R10
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> (dout == 8'h00));

  // R9
  status_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_now && !rd_start && mode == MODE_STAT && $stable(mode)) |-> $stable(dout));
endmodule

// File: tb/flash_cmd_front_tb.sv
module flash_cmd_front_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [19:0] addr = '0;
  logic [7:0]  din = '0;
  logic        eng_busy = 1'b0;
  logic [7:0]  status_in = 8'h80;
  logic [7:0]  dout;
  logic        dout_en;
  logic        erase_go;
  logic [19:0] erase_addr;
  logic        clr_stat;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic        seen_go, seen_clr;
  logic [19:0] seen_ea;
  logic [7:0]  rd_val;
  logic        rd_en;

  always #4 clk = ~clk;

  flash_cmd_front u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .eng_busy(eng_busy), .status_in(status_in),
    .dout(dout), .dout_en(dout_en), .erase_go(erase_go),
    .erase_addr(erase_addr), .clr_stat(clr_stat)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] stub(input logic [19:0] a);
    return {a[3:0], ~a[3:0]};
  endfunction

  task automatic wr(input logic [7:0] b, input logic [19:0] a);
    @(negedge clk);
    ce_n = 1'b0; we_n = 1'b0; din = b; addr = a;
    @(negedge clk);
    seen_go = erase_go; seen_clr = clr_stat; seen_ea = erase_addr;
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic rd(input logic [19:0] a);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    #1;
    rd_val = dout; rd_en = dout_en;
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset idle en", dout_en, 0);
    chk("R10 reset idle data", dout, 0);

    // R1 array sweep after reset, including aliased high addresses
    for (int i = 0; i < 16; i++) begin
      rd(20'(i)); chk("R1 array read", rd_val, stub(20'(i)));
    end
    rd(20'hABCD7); chk("R1 array alias", rd_val, stub(20'hABCD7));
    rd(20'hFFFFF); chk("R1 array top", rd_val, stub(20'hFFFFF));

    // R2 identifier sweep
    wr(8'h90, 20'h0);
    for (int i = 0; i < 8; i++) begin
      rd(20'(i));
      chk("R2 ident read", rd_val, (i == 0) ? 8'h89 : (i == 1) ? 8'hA2 : 8'h00);
    end
    rd(20'h10000); chk("R2 ident high", rd_val, 0);
    rd(20'h00001); chk("R4 ident persists", rd_val, 8'hA2);

    // R4 exhaustive unrecognised byte sweep from identifier mode
    for (int b = 0; b < 256; b++) begin
      if (b != 8'hFF && b != 8'h90 && b != 8'h70 && b != 8'h50 && b != 8'h20) begin
        wr(8'(b), 20'h0);
        rd(20'h0); chk("R4 unknown byte ignored", rd_val, 8'h89);
      end
    end

    // R8 clear pulse keeps identifier mode
    wr(8'h50, 20'h0);
    chk("R8 clear pulse", seen_clr, 1);
    chk("R8 no erase", seen_go, 0);
    @(negedge clk); chk("R8 single cycle", clr_stat, 0);
    rd(20'h0); chk("R8 mode kept", rd_val, 8'h89);

    // R3 status mode
    wr(8'h70, 20'h0);
    status_in = 8'h80;
    rd(20'h3); chk("R3 status read", rd_val, 8'h80);
    status_in = 8'h1C;
    rd(20'h0); chk("R3 status live", rd_val, 8'h1C);

    // R11 write with chip disabled
    @(negedge clk); we_n = 1'b0; din = 8'hFF;
    @(negedge clk); we_n = 1'b1;
    rd(20'h0); chk("R11 ce high ignored", rd_val, 8'h1C);

    // R5 busy blocks only FFH
    eng_busy = 1'b1;
    wr(8'hFF, 20'h0);
    rd(20'h2); chk("R5 busy ff ignored", rd_val, 8'h1C);
    wr(8'h90, 20'h0);
    rd(20'h1); chk("R5 busy ident ok", rd_val, 8'hA2);
    wr(8'hFF, 20'h0);
    rd(20'h1); chk("R5 busy ff ignored ident", rd_val, 8'hA2);
    eng_busy = 1'b0;
    wr(8'hFF, 20'h0);
    rd(20'h5); chk("R1 ff restores array", rd_val, stub(20'h5));

    // R6 erase pair
    wr(8'h20, 20'h00010);
    chk("R6 setup no go", seen_go, 0);
    rd(20'h6); chk("R6 setup keeps mode", rd_val, stub(20'h6));
    wr(8'hD0, 20'h12345);
    chk("R6 erase go", seen_go, 1);
    chk("R6 erase addr", seen_ea, 20'h12345);
    @(negedge clk); chk("R6 single cycle", erase_go, 0);
    status_in = 8'h00;
    rd(20'h6); chk("R6 status after erase", rd_val, 8'h00);

    // R6 erase accepted while busy
    eng_busy = 1'b1;
    wr(8'h90, 20'h0);
    wr(8'h20, 20'h0);
    wr(8'hD0, 20'hF0F00);
    chk("R6 busy erase go", seen_go, 1);
    chk("R6 busy erase addr", seen_ea, 20'hF0F00);
    eng_busy = 1'b0;

    // R7 broken pair
    wr(8'hFF, 20'h0);
    wr(8'h20, 20'h0);
    wr(8'h90, 20'h0);
    chk("R7 no go", seen_go, 0);
    status_in = 8'h88;
    rd(20'h0); chk("R7 status mode", rd_val, 8'h88);
    wr(8'hD0, 20'h0);
    chk("R7 lone confirm", seen_go, 0);
    rd(20'h0); chk("R7 still status", rd_val, 8'h88);

    // R9 freeze during a read
    status_in = 8'h80;
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; addr = 20'h0;
    #1 chk("R9 first cycle", dout, 8'h80);
    @(posedge clk); #1 status_in = 8'h81;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); chk("R9 frozen", dout, 8'h80);
    end
    oe_n = 1'b1;
    @(negedge clk); chk("R10 oe high", dout_en, 0);
    chk("R10 oe high data", dout, 0);
    oe_n = 1'b0;
    #1 chk("R9 refreshed", dout, 8'h81);
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;

    // R9 chip enable falling last decides capture
    @(negedge clk); oe_n = 1'b0; status_in = 8'h90;
    @(negedge clk); chk("R10 ce high", dout_en, 0);
    status_in = 8'hA0;
    @(negedge clk); ce_n = 1'b0;
    #1 chk("R9 later edge", dout, 8'hA0);
    @(posedge clk); #1 status_in = 8'hB0;
    @(negedge clk); chk("R9 later edge frozen", dout, 8'hA0);
    chk("R10 driving", dout_en, 1);
    ce_n = 1'b1; oe_n = 1'b1;

    // R1 reset returns to array mode
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(20'h9); chk("R1 reset mode", rd_val, stub(20'h9));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule